// File: doc/BRIEF.md
# Slot Hotplug Controller

This block keeps the hotplug bookkeeping for up to 32 slots on one bus, for a protocol in which the operating system does the work. It holds three bitmaps: the slots that hold a device, the slots that may be hot-removed, and the slots waiting for the OS to finish a removal. Software reads these bitmaps through a 16-byte register window. It asks for a removal to complete by writing a slot mask to the eject register. The slot logic sends the block one-cycle plug, unplug and boot-time (coldplug) event pulses. The block answers with a pulse that sets bit 1 of the general-purpose event status, and with one-cycle eject strobes that tell the slot logic to tear a device down.

Requests enter on a valid/ready handshake. `bus_ready` is high only while the block is running. It goes low during the drain and rebuild phases that follow a hard reset or a platform reset request, so a requester must hold `bus_valid` and its fields until it sees ready. A read returns its data with `rd_valid` exactly one cycle after it is accepted. That response has no back-pressure: the requester must take it in that cycle. Writes return no response. The hotplug-capable bitmap is sampled from `fixed_slot` only when the bitmaps are rebuilt. The eject path reads `fixed_slot` live at the moment it acts.

Top module: `slot_hotplug_ctrl`

## Requirements
- R1: A read at offset 0x0 returns the present bitmap ANDed with the hotplug-capable bitmap.
- R2: A read at offset 0x4 returns the pending-removal bitmap, a read at 0xC returns the hotplug-capable bitmap, and a read at 0x8 returns 0.
- R3: Only accesses with `bus_be` = 4'hF at offsets 0x0, 0x4, 0x8 or 0xC are decoded. Any other access reads 0, and any write other than a full-width write to 0x8 changes no state and produces no strobe.
- R4: A full-width write to 0x8 selects the lowest set bit of the written data as the slot. It clears that slot's pending-removal bit and drives `eject_strobe` one-hot for that slot in the next cycle.
- R5: After an eject, the slot's present bit is cleared unless `fixed_slot` is set for that slot at that moment.
- R6: An eject write whose data is zero in the slot bits affects no slot and produces no strobe.
- R7: A pulse on `ev_plug` sets the slot's present bit and gives a one-cycle `gpe_hp_set` pulse in the next cycle.
- R8: A pulse on `ev_unplug` sets the slot's pending-removal bit and gives a one-cycle `gpe_hp_set` pulse in the next cycle.
- R9: A pulse on `ev_cold` sets the slot's present bit and produces no `gpe_hp_set` pulse.
- R10: After `sys_reset_req`, the block holds `bus_ready` low and ejects pending removals one slot per clock, lowest slot first, until none remain.
- R11: Once the drain is done, and also after a hard reset, hotplug-capable becomes the inverse of `fixed_slot`, present becomes `occupied`, and pending-removal is empty.
- R12: `rd_valid` pulses exactly one cycle after each accepted read and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| sys_reset_req | input | 1 | Platform reset request pulse; starts the drain and rebuild |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Request accepted when high; low during drain and rebuild |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset in the window |
| bus_be | input | 4 | Byte enables; only 4'hF is decoded |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after acceptance |
| rd_data | output | 32 | Read data |
| ev_plug | input | NUM_SLOTS | Per-slot hot-plug event pulses |
| ev_unplug | input | NUM_SLOTS | Per-slot hot-unplug event pulses |
| ev_cold | input | NUM_SLOTS | Per-slot boot-time presence pulses |
| fixed_slot | input | NUM_SLOTS | Per-slot flag: device cannot be hot-removed |
| occupied | input | NUM_SLOTS | Per-slot occupancy used when the bitmaps are rebuilt |
| gpe_hp_set | output | 1 | Pulse that sets bit 1 of the event status |
| eject_strobe | output | NUM_SLOTS | One-hot pulse telling the slot logic to tear down a device |

## Verification
Every wrong bit in the present, capable or pending-removal bitmaps shows up in the next register read: in the up value, the down value or the removable value. It does not show up anywhere else, so each bitmap is read back after every event and every eject. A wrong slot selection shows in `eject_strobe` in the cycle right after the write or drain step. A drain that runs in the wrong order, or one that skips a slot, shows as a wrong sequence of strobes before `bus_ready` rises again. A missing or extra event pulse shows as a wrong count of `gpe_hp_set` pulses.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam logic [3:0] OFF_UP    = 4'h0;
  localparam logic [3:0] OFF_DOWN  = 4'h4;
  localparam logic [3:0] OFF_EJECT = 4'h8;
  localparam logic [3:0] OFF_RMV   = 4'hC;
  localparam logic [3:0] BE_FULL   = 4'hF;

  typedef enum logic [1:0] {
    PH_DRAIN   = 2'd0,
    PH_REBUILD = 2'd1,
    PH_RUN     = 2'd2
  } hp_phase_e;
endpackage

// File: rtl/hp_lowest_bit.sv
module hp_lowest_bit #(
  parameter int W = 32
) (
  input  logic [W-1:0] vec,
  output logic [W-1:0] onehot
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign onehot[i]  = vec[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | vec[i];
  end
endmodule

// File: rtl/hp_slot_state.sv
module hp_slot_state
  import hp_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  hp_phase_e            phase,
  input  logic [NUM_SLOTS-1:0] ej_onehot,
  input  logic [NUM_SLOTS-1:0] ev_plug,
  input  logic [NUM_SLOTS-1:0] ev_unplug,
  input  logic [NUM_SLOTS-1:0] ev_cold,
  input  logic [NUM_SLOTS-1:0] fixed_slot,
  input  logic [NUM_SLOTS-1:0] occupied,
  output logic [NUM_SLOTS-1:0] present,
  output logic [NUM_SLOTS-1:0] down,
  output logic [NUM_SLOTS-1:0] capable
);
  logic [NUM_SLOTS-1:0] drop;
  assign drop = ej_onehot & ~fixed_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= '0;
      down    <= '0;
      capable <= '1;
    end else if (phase == PH_REBUILD) begin
      capable <= ~fixed_slot;
      present <= occupied;
      down    <= ev_unplug;
    end else begin
      present <= (present & ~drop) | ev_plug | ev_cold;
      down    <= (down & ~ej_onehot) | ev_unplug;
    end
  end
endmodule

// File: rtl/hp_reg_read.sv
module hp_reg_read
  import hp_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic [3:0]           addr,
  input  logic [3:0]           be,
  input  logic [NUM_SLOTS-1:0] present,
  input  logic [NUM_SLOTS-1:0] down,
  input  logic [NUM_SLOTS-1:0] capable,
  output logic [31:0]          data
);
  always_comb begin
    data = '0;
    if (be == BE_FULL) begin
      unique case (addr)
        OFF_UP:   data = 32'(present & capable);
        OFF_DOWN: data = 32'(down);
        OFF_RMV:  data = 32'(capable);
        default:  data = '0;
      endcase
    end
  end
endmodule

// File: rtl/slot_hotplug_ctrl.sv
module slot_hotplug_ctrl
  import hp_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sys_reset_req,
  input  logic                 bus_valid,
  output logic                 bus_ready,
  input  logic                 bus_write,
  input  logic [3:0]           bus_addr,
  input  logic [3:0]           bus_be,
  input  logic [31:0]          bus_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  input  logic [NUM_SLOTS-1:0] ev_plug,
  input  logic [NUM_SLOTS-1:0] ev_unplug,
  input  logic [NUM_SLOTS-1:0] ev_cold,
  input  logic [NUM_SLOTS-1:0] fixed_slot,
  input  logic [NUM_SLOTS-1:0] occupied,
  output logic                 gpe_hp_set,
  output logic [NUM_SLOTS-1:0] eject_strobe
);
  hp_phase_e            phase;
  logic [NUM_SLOTS-1:0] present, down, capable;
  logic [NUM_SLOTS-1:0] ej_src, ej_onehot;
  logic [31:0]          rd_mux;
  logic                 accept, wr_eject;

  assign bus_ready = (phase == PH_RUN);
  assign accept    = bus_valid & bus_ready;
  assign wr_eject  = accept & bus_write & (bus_addr == OFF_EJECT) & (bus_be == BE_FULL);
  assign ej_src    = (phase == PH_DRAIN) ? down
                   : (wr_eject ? bus_wdata[NUM_SLOTS-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_DRAIN;
    end else begin
      unique case (phase)
        PH_DRAIN:   if (down == '0) phase <= PH_REBUILD;
        PH_REBUILD: phase <= PH_RUN;
        default:    if (sys_reset_req) phase <= PH_DRAIN;
      endcase
    end
  end

  hp_lowest_bit #(.W(NUM_SLOTS)) u_pick (
    .vec    (ej_src),
    .onehot (ej_onehot)
  );

  hp_slot_state #(.NUM_SLOTS(NUM_SLOTS)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .ej_onehot  (ej_onehot),
    .ev_plug    (ev_plug),
    .ev_unplug  (ev_unplug),
    .ev_cold    (ev_cold),
    .fixed_slot (fixed_slot),
    .occupied   (occupied),
    .present    (present),
    .down       (down),
    .capable    (capable)
  );

  hp_reg_read #(.NUM_SLOTS(NUM_SLOTS)) u_read (
    .addr    (bus_addr),
    .be      (bus_be),
    .present (present),
    .down    (down),
    .capable (capable),
    .data    (rd_mux)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      gpe_hp_set   <= 1'b0;
      eject_strobe <= '0;
    end else begin
      rd_valid     <= accept & ~bus_write;
      if (accept & ~bus_write) rd_data <= rd_mux;
      gpe_hp_set   <= |(ev_plug | ev_unplug);
      eject_strobe <= ej_onehot;
    end
  end
endmodule

// File: rtl/hp_ctrl_chk.sv
module hp_ctrl_chk #(
  parameter int NUM_SLOTS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_ready,
  input logic                 bus_write,
  input logic [3:0]           bus_addr,
  input logic [3:0]           bus_be,
  input logic [31:0]          bus_wdata,
  input logic                 rd_valid,
  input logic [NUM_SLOTS-1:0] ev_plug,
  input logic [NUM_SLOTS-1:0] ev_unplug,
  input logic                 gpe_hp_set,
  input logic [NUM_SLOTS-1:0] eject_strobe
);
  // R4
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eject_strobe));

  // R6
  zero_eject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && bus_write && bus_addr == 4'h8 && bus_be == 4'hF
     && bus_wdata[NUM_SLOTS-1:0] == '0) |=> (eject_strobe == '0));

  // R7
  gpe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpe_hp_set |-> $past(|(ev_plug | ev_unplug)));

  // R8
  unplug_gpe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_unplug) |=> gpe_hp_set);

  // R12
  rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(bus_valid && bus_ready && !bus_write));
endmodule

bind slot_hotplug_ctrl hp_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_ready    (bus_ready),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_be       (bus_be),
  .bus_wdata    (bus_wdata),
  .rd_valid     (rd_valid),
  .ev_plug      (ev_plug),
  .ev_unplug    (ev_unplug),
  .gpe_hp_set   (gpe_hp_set),
  .eject_strobe (eject_strobe)
);

// File: tb/slot_hotplug_ctrl_tb.sv
module slot_hotplug_ctrl_tb;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sys_reset_req = 1'b0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic          bus_ready, rd_valid, gpe_hp_set;
  logic [3:0]    bus_addr = '0, bus_be = '0;
  logic [31:0]   bus_wdata = '0, rd_data;
  logic [N-1:0]  ev_plug = '0, ev_unplug = '0, ev_cold = '0;
  logic [N-1:0]  fixed_slot = 32'h1, occupied = 32'h13;
  logic [N-1:0]  eject_strobe;

  always #2 clk = ~clk;

  slot_hotplug_ctrl #(.NUM_SLOTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .sys_reset_req(sys_reset_req),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ev_plug(ev_plug), .ev_unplug(ev_unplug), .ev_cold(ev_cold),
    .fixed_slot(fixed_slot), .occupied(occupied),
    .gpe_hp_set(gpe_hp_set), .eject_strobe(eject_strobe)
  );

  int n_cmp = 0, n_bad = 0, gpe_seen = 0;
  bit done = 1'b0;
  logic [31:0]  rd_exp_q[$];
  string        rd_tag_q[$];
  logic [N-1:0] ej_exp_q[$];
  string        ej_tag_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected items as the design produces results
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (rd_exp_q.size() == 0) check("R12 unexpected read response", 32'h1, 32'h0);
        else check(rd_tag_q.pop_front(), rd_data, rd_exp_q.pop_front());
      end
      if (eject_strobe != '0) begin
        if (ej_exp_q.size() == 0) check("R6 unexpected eject strobe", 32'(eject_strobe), 32'h0);
        else check(ej_tag_q.pop_front(), 32'(eject_strobe), 32'(ej_exp_q.pop_front()));
      end
      if (gpe_hp_set) gpe_seen++;
    end
  end

  task automatic bus_op(input logic wr, input logic [3:0] addr, input logic [3:0] be,
                        input logic [31:0] wdata);
    while (!bus_ready) @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = addr; bus_be = be; bus_wdata = wdata;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] addr, input logic [3:0] be,
                    input logic [31:0] exp, input string tag);
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    bus_op(1'b0, addr, be, 32'h0);
  endtask

  task automatic ej(input logic [31:0] data, input logic [N-1:0] exp_strobe, input string tag);
    if (exp_strobe != '0) begin
      ej_exp_q.push_back(exp_strobe);
      ej_tag_q.push_back(tag);
    end
    bus_op(1'b1, 4'h8, 4'hF, data);
  endtask

  task automatic pulse(input int kind, input int slot);
    if (kind == 0) ev_plug[slot] = 1'b1;
    else if (kind == 1) ev_unplug[slot] = 1'b1;
    else ev_cold[slot] = 1'b1;
    @(negedge clk);
    ev_plug = '0; ev_unplug = '0; ev_cold = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 hard reset rebuild
    rd(4'h0, 4'hF, 32'h12, "R11 R1 up after reset");
    rd(4'hC, 4'hF, 32'hFFFF_FFFE, "R11 R2 removable after reset");
    rd(4'h4, 4'hF, 32'h0, "R11 down after reset");

    pulse(0, 7);                                   // R7
    rd(4'h0, 4'hF, 32'h92, "R7 up after plug");
    check("R7 gpe count", gpe_seen, 1);
    pulse(2, 9);                                   // R9
    rd(4'h0, 4'hF, 32'h292, "R9 up after coldplug");
    check("R9 no gpe on coldplug", gpe_seen, 1);
    pulse(1, 4);                                   // R8
    pulse(1, 7);
    rd(4'h4, 4'hF, 32'h90, "R8 down after unplug");
    check("R8 gpe count", gpe_seen, 3);

    ej(32'hF0, 32'h10, "R4 lowest-bit eject");
    rd(4'h4, 4'hF, 32'h80, "R4 down cleared");
    rd(4'h0, 4'hF, 32'h282, "R5 present cleared");
    ej(32'h0, '0, "R6");
    rd(4'h4, 4'hF, 32'h80, "R6 zero eject no effect");

    bus_op(1'b1, 4'h8, 4'h3, 32'h80);              // R3 partial eject write
    rd(4'h4, 4'hF, 32'h80, "R3 partial write ignored");
    bus_op(1'b1, 4'h0, 4'hF, 32'hFFFF_FFFF);       // R3 write to up
    rd(4'h0, 4'hF, 32'h282, "R3 write to up ignored");
    rd(4'h2, 4'hF, 32'h0, "R3 unaligned read zero");
    rd(4'h4, 4'h1, 32'h0, "R3 partial read zero");
    rd(4'h8, 4'hF, 32'h0, "R2 eject reads zero");

    fixed_slot = 32'h3;
    ej(32'h2, 32'h2, "R5 fixed slot strobe");
    rd(4'h0, 4'hF, 32'h282, "R5 fixed slot keeps present");
    fixed_slot = 32'h1;

    pulse(1, 10);
    rd(4'h4, 4'hF, 32'h480, "R8 down before drain");
    // R10 drain lowest first
    ej_exp_q.push_back(32'h80);  ej_tag_q.push_back("R10 drain first slot");
    ej_exp_q.push_back(32'h400); ej_tag_q.push_back("R10 drain second slot");
    sys_reset_req = 1'b1;
    @(negedge clk);
    sys_reset_req = 1'b0;
    check("R10 ready low during drain", 32'(bus_ready), 32'h0);
    rd(4'h0, 4'hF, 32'h12, "R11 up after drain");
    rd(4'h4, 4'hF, 32'h0, "R11 down after drain");
    rd(4'hC, 4'hF, 32'hFFFF_FFFE, "R11 removable after drain");
    repeat (3) @(negedge clk);
    check("R10 all strobes seen", ej_exp_q.size(), 0);
    check("R12 all reads answered", rd_exp_q.size(), 0);
    check("R7 final gpe count", gpe_seen, 4);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule